// File: doc/BRIEF.md
# Unaligned Sixteen-Byte Fetch Window Buffer

This block sits between a fetch address source and an instruction cache that returns whole 64-byte lines. It keeps a single 16-byte window of instruction bytes. A fetch address that lands inside the held window is answered from that window with no cache traffic. Any other address is a miss. On a miss the block reads the line that holds the address and builds a new window of 16 bytes that starts exactly at that address. When those 16 bytes run past the end of the line, it reads the following line as well and joins the bytes from both.

The fetch side is valid/ready. A request moves on a cycle with `req_valid` and `req_ready` both high. `req_ready` is high only while the block is idle, so one fetch is in progress at a time. The result side is also valid/ready. `out_valid` stays high, and the window data and start address stay frozen, until `out_ready` is seen high. The cache request side is valid/ready too: the line address is held steady until `mem_req_ready`. The cache answers with a single `mem_rsp_valid` pulse carrying the line, and there is never more than one read in flight.

`flush` is a plain control pin used on a redirect, and `access_count` is a plain status output.

Top module: `fb_fetch_buffer`

## Requirements
- R1: After reset, `req_ready` is 1, `out_valid` is 0, `mem_req_valid` is 0 and `access_count` is 0, and no window is held.
- R2: A miss at an address whose low six bits are 0 issues exactly one line read. The line address is the fetch address with its low six bits dropped. The result has `out_addr` equal to the fetch address, and byte k of `out_data` (bits 8k+7..8k) equals the memory byte at address+k.
- R3: A miss whose offset within the line is 1 to 48 issues exactly one read of the line holding the address. The result holds the 16 bytes starting at the address. An offset of exactly 48 still needs only one line.
- R4: A miss whose offset within the line is 49 to 63 issues two reads: first the line holding the address, then the next line (wrapping at the top of the address space). `out_valid` rises only after both responses. Byte k of the result is the memory byte at address+k, modulo 2^32.
- R5: A fetch whose address minus the held window's start, taken unsigned, is below 16 is a hit. This holds even when the window crosses a line boundary. A hit issues no cache request and leaves `access_count` unchanged. It returns the held window, with `out_addr` equal to the held start.
- R6: `flush` drops the held window, so the next fetch misses even at the same address. A `flush` in the same cycle as an accepted request forces that request to miss. The window that request builds is kept. A `flush` while a miss is filling lets that fill be delivered but not kept.
- R7: `access_count` (32 bits) rises by exactly one on each cycle in which a cache request is accepted (`mem_req_valid` and `mem_req_ready` both 1), and is otherwise unchanged.
- R8: `req_ready` is low from the cycle after a request is accepted until the cycle after its result is taken. While `mem_req_valid` waits for `mem_req_ready`, the line address is held steady. Only one cache read is outstanding.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_addr` hold. The cycle after `out_ready` is seen, `out_valid` is 0.
- R10: After a miss, the window just built becomes the held window for R5 hits. A later miss replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Block can accept a fetch request |
| req_addr | input | 32 | Byte address of the fetch |
| flush | input | 1 | Drop the held window (redirect) |
| mem_req_valid | output | 1 | Cache line read requested |
| mem_req_ready | input | 1 | Cache accepts the line read |
| mem_req_line | output | 26 | Line address (byte address divided by 64) |
| mem_rsp_valid | input | 1 | One-cycle pulse carrying the requested line |
| mem_rsp_data | input | 512 | Line data, byte j at bits 8j+7..8j |
| out_valid | output | 1 | Window result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Start address of the returned window |
| out_data | output | 128 | Window bytes, byte k at bits 8k+7..8k |
| access_count | output | 32 | Number of accepted cache line reads |

## Verification
The embedded checks assume the cache side behaves. A response pulse only comes after a line read has been accepted and before the next one is requested, and it carries that line. The bench's cache model obeys this: it raises `mem_req_ready` only after it sees a pending request, and it answers each accepted read with exactly one pulse after a varying delay. It also varies its accept delay so that request-hold behaviour gets exercised. Fetch requests and `out_ready` are driven only through the handshake, with stalls of zero to two cycles on the result side. A behavioural model of the held window predicts the hit or miss outcome, the expected lines and their order, the data and the access count for every fetch. Readiness is checked on every clock.

// File: rtl/fb_pkg.sv
package fb_pkg;

  typedef enum logic [2:0] {
    FB_IDLE    = 3'd0,
    FB_REQ_LO  = 3'd1,
    FB_WAIT_LO = 3'd2,
    FB_REQ_HI  = 3'd3,
    FB_WAIT_HI = 3'd4,
    FB_SEND    = 3'd5
  } fb_state_e;

endpackage

// File: rtl/fb_hit_detect.sv
module fb_hit_detect #(
  parameter int ADDR_W    = 32,
  parameter int WIN_BYTES = 16
) (
  input  logic              held_ok,
  input  logic [ADDR_W-1:0] held_base,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              hit
);

  logic [ADDR_W-1:0] distance;

  always_comb begin
    distance = probe_addr - held_base;
    hit      = held_ok && (distance < ADDR_W'(WIN_BYTES));
  end

endmodule

// File: rtl/fb_window_merge.sv
module fb_window_merge #(
  parameter int LINE_BYTES = 64,
  parameter int WIN_BYTES  = 16
) (
  input  logic                          upper_phase,
  input  logic [$clog2(LINE_BYTES)-1:0] start_off,
  input  logic [LINE_BYTES*8-1:0]       line_bytes,
  input  logic [WIN_BYTES*8-1:0]        win_in,
  output logic [WIN_BYTES*8-1:0]        win_out
);

  localparam int OFF_W = $clog2(LINE_BYTES);

  for (genvar k = 0; k < WIN_BYTES; k++) begin : g_byte
    logic [OFF_W:0] src_idx;
    logic           from_line;

    always_comb begin
      src_idx   = {1'b0, start_off} + (OFF_W+1)'(k);
      from_line = upper_phase ? src_idx[OFF_W] : !src_idx[OFF_W];
      if (from_line) begin
        win_out[k*8 +: 8] = line_bytes[src_idx[OFF_W-1:0]*8 +: 8];
      end else begin
        win_out[k*8 +: 8] = win_in[k*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/fb_access_counter.sv
module fb_access_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (bump) begin
      count <= count + CNT_W'(1);
    end
  end

  // R7: exactly one step per accepted line read, no drift otherwise
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bump |=> count == $past(count) + CNT_W'(1));
  p_count_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bump |=> $stable(count));

endmodule

// File: rtl/fb_fetch_buffer.sv
module fb_fetch_buffer
  import fb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int WIN_BYTES  = 16,
  parameter int CNT_W      = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [ADDR_W-1:0]                    req_addr,
  input  logic                                 flush,
  output logic                                 mem_req_valid,
  input  logic                                 mem_req_ready,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] mem_req_line,
  input  logic                                 mem_rsp_valid,
  input  logic [LINE_BYTES*8-1:0]              mem_rsp_data,
  output logic                                 out_valid,
  input  logic                                 out_ready,
  output logic [ADDR_W-1:0]                    out_addr,
  output logic [WIN_BYTES*8-1:0]               out_data,
  output logic [CNT_W-1:0]                     access_count
);

  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int LINE_W     = ADDR_W - OFF_W;
  localparam int WIN_W      = WIN_BYTES * 8;
  localparam int LAST_SAFE  = LINE_BYTES - WIN_BYTES;

  fb_state_e          state_q;
  logic [ADDR_W-1:0]  base_q;
  logic [WIN_W-1:0]   win_q;
  logic               held_q;
  logic               keep_q;
  logic               straddle_q;

  logic               accept;
  logic               hit;
  logic               mem_fire;
  logic               crosses;
  logic [LINE_W-1:0]  base_line;
  logic [WIN_W-1:0]   merged;

  assign accept    = req_valid && req_ready;
  assign mem_fire  = mem_req_valid && mem_req_ready;
  assign base_line = base_q[ADDR_W-1:OFF_W];
  assign crosses   = req_addr[OFF_W-1:0] > OFF_W'(LAST_SAFE);

  assign req_ready     = (state_q == FB_IDLE);
  assign out_valid     = (state_q == FB_SEND);
  assign out_addr      = base_q;
  assign out_data      = win_q;
  assign mem_req_valid = (state_q == FB_REQ_LO) || (state_q == FB_REQ_HI);
  assign mem_req_line  = (state_q == FB_REQ_HI) ? base_line + LINE_W'(1) : base_line;

  fb_hit_detect #(
    .ADDR_W    (ADDR_W),
    .WIN_BYTES (WIN_BYTES)
  ) u_hit (
    .held_ok    (held_q && !flush),
    .held_base  (base_q),
    .probe_addr (req_addr),
    .hit        (hit)
  );

  fb_window_merge #(
    .LINE_BYTES (LINE_BYTES),
    .WIN_BYTES  (WIN_BYTES)
  ) u_merge (
    .upper_phase (state_q == FB_WAIT_HI),
    .start_off   (base_q[OFF_W-1:0]),
    .line_bytes  (mem_rsp_data),
    .win_in      (win_q),
    .win_out     (merged)
  );

  fb_access_counter #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (mem_fire),
    .count (access_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= FB_IDLE;
      base_q     <= '0;
      win_q      <= '0;
      held_q     <= 1'b0;
      keep_q     <= 1'b0;
      straddle_q <= 1'b0;
    end else begin
      unique case (state_q)
        FB_IDLE: begin
          if (accept) begin
            if (hit) begin
              state_q <= FB_SEND;
            end else begin
              base_q     <= req_addr;
              straddle_q <= crosses;
              held_q     <= 1'b0;
              keep_q     <= 1'b1;
              state_q    <= FB_REQ_LO;
            end
          end
        end
        FB_REQ_LO: begin
          if (mem_req_ready) state_q <= FB_WAIT_LO;
        end
        FB_WAIT_LO: begin
          if (mem_rsp_valid) begin
            win_q <= merged;
            if (straddle_q) begin
              state_q <= FB_REQ_HI;
            end else begin
              held_q  <= keep_q;
              state_q <= FB_SEND;
            end
          end
        end
        FB_REQ_HI: begin
          if (mem_req_ready) state_q <= FB_WAIT_HI;
        end
        FB_WAIT_HI: begin
          if (mem_rsp_valid) begin
            win_q   <= merged;
            held_q  <= keep_q;
            state_q <= FB_SEND;
          end
        end
        FB_SEND: begin
          if (out_ready) state_q <= FB_IDLE;
        end
        default: state_q <= FB_IDLE;
      endcase
      if (flush) begin
        held_q <= 1'b0;
        if (!accept) keep_q <= 1'b0;
      end
    end
  end

  // R8: a pending line read keeps its address until taken
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_line));

  // R9: a stalled result does not move
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_addr));

  // R8: while accepting, nothing else is in flight
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !out_valid && !mem_req_valid);

  // R8: responses only arrive for an accepted read
  p_rsp_expected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (state_q == FB_WAIT_LO) || (state_q == FB_WAIT_HI));

  // R5: a hit goes straight to the result without a line read
  p_hit_no_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit |=> out_valid && !mem_req_valid && $stable(access_count));

endmodule

// File: tb/tb_fb_fetch_buffer.sv
module tb_fb_fetch_buffer;

  localparam int AW = 32;
  localparam int LW = AW - 6;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid;
  logic            req_ready;
  logic [AW-1:0]   req_addr;
  logic            flush;
  logic            mem_req_valid;
  logic            mem_req_ready;
  logic [LW-1:0]   mem_req_line;
  logic            mem_rsp_valid;
  logic [511:0]    mem_rsp_data;
  logic            out_valid;
  logic            out_ready;
  logic [AW-1:0]   out_addr;
  logic [127:0]    out_data;
  logic [31:0]     access_count;

  always #4 clk = ~clk;

  fb_fetch_buffer dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .flush         (flush),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_line  (mem_req_line),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_addr      (out_addr),
    .out_data      (out_data),
    .access_count  (access_count)
  );

  int            n_vec = 0;
  int            n_bad = 0;
  logic          busy_exp = 1'b0;
  logic [LW-1:0] line_q[$];
  int            rsp_cnt = 0;
  int            stall_sel = 0;
  bit            model_held = 0;
  logic [AW-1:0] model_base = '0;
  int            exp_count = 0;

  function automatic logic [7:0] mbyte(input logic [AW-1:0] a);
    return 8'(a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [511:0] line_data(input logic [LW-1:0] ln);
    logic [511:0] d;
    for (int i = 0; i < 64; i++) d[i*8 +: 8] = mbyte({ln, 6'(i)});
    return d;
  endfunction

  function automatic logic [127:0] win_data(input logic [AW-1:0] a);
    logic [127:0] d;
    for (int i = 0; i < 16; i++) d[i*8 +: 8] = mbyte(a + AW'(i));
    return d;
  endfunction

  task automatic check_eq(input string req, input string what,
                          input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // per-clock readiness comparison against the model (R8)
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) check_eq("R8", "req_ready per clock", 128'(req_ready), 128'(!busy_exp));
    end
  end

  // cache model: accepts one read at a time, answers with one pulse
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        int st;
        st = stall_sel % 3;
        stall_sel++;
        repeat (st) @(negedge clk);
        line_q.push_back(mem_req_line);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (stall_sel % 2) @(negedge clk);
        mem_rsp_data  = line_data(line_q[$]);
        mem_rsp_valid = 1'b1;
        rsp_cnt++;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    finish_run();
  end

  task automatic fetch(input logic [AW-1:0] a, input int hold,
                       input bit fl_with, input bit fl_mid);
    bit            hit;
    logic [AW-1:0] exp_base;
    int            nl;
    logic [LW-1:0] l0;
    logic [LW-1:0] l1;
    logic [127:0]  first_data;
    @(negedge clk);
    hit      = model_held && !fl_with && ((a - model_base) < AW'(16));
    exp_base = hit ? model_base : a;
    nl       = hit ? 0 : ((a[5:0] > 6'd48) ? 2 : 1);
    l0       = a[AW-1:6];
    l1       = l0 + LW'(1);
    line_q.delete();
    rsp_cnt  = 0;
    req_valid = 1'b1;
    req_addr  = a;
    flush     = fl_with;
    busy_exp  = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    flush     = 1'b0;
    if (fl_mid) begin
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
    end
    while (!out_valid) @(negedge clk);
    exp_count += nl;
    check_eq(hit ? "R5" : "R2", "out_addr", 128'(out_addr), 128'(exp_base));
    check_eq(nl == 2 ? "R4" : "R3", "out_data", out_data, win_data(exp_base));
    check_eq("R7", "access_count", 128'(access_count), 128'(exp_count));
    check_eq(hit ? "R5" : "R10", "line reads", 128'(line_q.size()), 128'(nl));
    check_eq("R4", "responses before valid", 128'(rsp_cnt), 128'(nl));
    if (nl >= 1 && line_q.size() >= 1) check_eq("R2", "first line", 128'(line_q[0]), 128'(l0));
    if (nl == 2 && line_q.size() >= 2) check_eq("R4", "second line", 128'(line_q[1]), 128'(l1));
    first_data = out_data;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check_eq("R9", "held valid", 128'(out_valid), 128'(1));
      check_eq("R9", "held data", out_data, first_data);
    end
    out_ready = 1'b1;
    busy_exp  = 1'b0;
    @(negedge clk);
    out_ready = 1'b0;
    check_eq("R9", "valid after take", 128'(out_valid), 128'(0));
    if (!hit) begin
      model_base = a;
      model_held = 1;
    end
    if (fl_mid) model_held = 0;
  endtask

  task automatic flush_idle();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    model_held = 0;
  endtask

  initial begin
    logic [31:0] lcg;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    flush     = 1'b0;
    out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_eq("R1", "req_ready", 128'(req_ready), 128'(1));
    check_eq("R1", "out_valid", 128'(out_valid), 128'(0));
    check_eq("R1", "mem_req_valid", 128'(mem_req_valid), 128'(0));
    check_eq("R1", "access_count", 128'(access_count), 128'(0));
    rst_n = 1'b1;

    fetch(32'h0000_1000, 0, 0, 0);  // R2 aligned miss
    fetch(32'h0000_1004, 1, 0, 0);  // R5 hit inside window
    fetch(32'h0000_100F, 0, 0, 0);  // R5 last byte of window
    fetch(32'h0000_1010, 2, 0, 0);  // R10 just past window: miss
    fetch(32'h0000_1025, 0, 0, 0);  // R3 unaligned, one line
    fetch(32'h0000_1070, 0, 0, 0);  // R3 offset 48 stays in one line
    fetch(32'h0000_1071, 1, 0, 0);  // R4 offset 49 straddles
    fetch(32'h0000_107E, 0, 0, 0);  // R5 hit across line boundary
    fetch(32'h0000_10BF, 0, 0, 0);  // R4 offset 63
    flush_idle();
    fetch(32'h0000_10BF, 0, 0, 0);  // R6 same address misses after flush
    fetch(32'h0000_10C0, 0, 1, 0);  // R6 flush with request forces miss
    fetch(32'h0000_10C2, 0, 0, 0);  // R6 window built under flush is kept
    fetch(32'h0000_2222, 0, 0, 1);  // R6 flush during fill
    fetch(32'h0000_2222, 0, 0, 0);  // R6 not kept: miss again
    fetch(32'hFFFF_FFF8, 2, 0, 0);  // R4 wrap at top of address space
    fetch(32'h0000_0002, 0, 0, 0);  // R5 hit in wrapped window

    lcg = 32'h1234_5678;
    for (int n = 0; n < 60; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      fetch(32'h0000_3000 + AW'(lcg[23:16]), int'(lcg[9:8]) % 3, 1'b0, 1'b0);
    end

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule